// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour table in which each entry carries an 8-bit red, an 8-bit green and an 8-bit blue value. Software fills the table through a small 32-bit register window with a write strobe. One register picks the entry to load. A second register accepts the colour bytes one write at a time, always in the order red, green, blue. An internal phase counter tracks which component comes next. Once an entry is complete, the entry pointer moves forward on its own, so software can stream a whole table after setting the start entry only once.

A separate pixel port serves the display path. It takes an 8-bit pixel value and, one clock later, returns that entry's 24-bit colour. The pixel port runs in parallel with loading and shares no state with the load pointer. Each colour byte becomes visible to the pixel port as soon as it is written.

Top module: `clut_loader`

## Requirements
- R1: A write to byte offset 0x0 loads the entry pointer from write-data bits 31:24 and returns the component phase to red.
- R2: Each write to byte offset 0x4 stores write-data bits 31:24 into one component of the entry named by the pointer. Successive writes fill red, then green, then blue.
- R3: The write that stores blue advances the entry pointer by one and returns the phase to red. From entry 255 the pointer wraps to entry 0.
- R4: After reset, entries 0 to 254 read as black (0x000000) and entry 255 reads as white (0xFFFFFF). The pointer is 0 and the phase is red, so the first three data writes fill entry 0.
- R5: `bus_rdata` is zero at all times, whatever the address or write activity.
- R6: A write to any window offset other than 0x0 and 0x4 changes neither the table, the pointer nor the phase.
- R7: A single component write takes effect on its own. A lookup started on the clock after a red or green write returns the new byte, while the components not yet written keep their old values.
- R8: `pix_color` is registered. It shows the colour of the `pix_idx` sampled at the previous rising edge, packed as red in bits 23:16, green in 15:8 and blue in 7:0. It does not depend on the entry pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset within the 16-byte register window |
| bus_wr | input | 1 | Write strobe for one full 32-bit access |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Pixel value to look up |
| pix_color | output | 24 | Registered colour of the looked-up entry |

## Verification
The pointer and phase cannot be read back, and a half-loaded entry can only be seen through the pixel port, so the bench has to infer them. To do this it interleaves loads with lookups of the entry being filled: after a red-only write it checks for the new red with the old green and blue. It also restarts the phase mid-entry by rewriting the pointer, and drives the pointer through entry 255 to check the wrap into entry 0. Stray writes to the unused offsets are mixed into a seeded random stream, and each one is followed by data writes whose landing place shows whether the pointer or phase moved.

// File: rtl/clut_pkg.sv
package clut_pkg;

    parameter int unsigned COMP_W  = 8;
    parameter int unsigned BUS_W   = 32;
    parameter int unsigned N_COMP  = 3;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } rgb_t;

    // colour byte carried by a register write
    function automatic logic [COMP_W-1:0] lane_byte(input logic [BUS_W-1:0] d);
        return d[BUS_W-1 -: COMP_W];
    endfunction

    // power-up value of one component: only the last entry is lit
    function automatic logic [COMP_W-1:0] init_byte(input int unsigned idx,
                                                    input int unsigned entries);
        return (idx == entries - 1) ? {COMP_W{1'b1}} : {COMP_W{1'b0}};
    endfunction

endpackage

// File: rtl/clut_regif.sv
module clut_regif
    import clut_pkg::*;
#(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned ADDR_W  = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [N_COMP-1:0] comp_we,
    output logic [IDX_W-1:0]  entry,
    output logic [COMP_W-1:0] wbyte,
    output logic [1:0]        phase_o
);
    localparam logic [ADDR_W-1:0] OFS_PTR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(4);
    localparam logic [IDX_W-1:0]  LAST     = IDX_W'(ENTRIES - 1);

    phase_e           phase_q;
    logic [IDX_W-1:0] ptr_q;
    logic             hit_ptr;
    logic             hit_data;

    assign hit_ptr  = wr && (addr == OFS_PTR);
    assign hit_data = wr && (addr == OFS_DATA);
    assign wbyte    = lane_byte(wdata);
    assign entry    = ptr_q;
    assign phase_o  = phase_q;

    // an unused phase code behaves as red
    always_comb begin
        comp_we = '0;
        case (phase_q)
            PH_GRN:  comp_we[1] = hit_data;
            PH_BLU:  comp_we[2] = hit_data;
            default: comp_we[0] = hit_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            phase_q <= PH_RED;
        end else if (hit_ptr) begin
            ptr_q   <= wbyte[IDX_W-1:0];
            phase_q <= PH_RED;
        end else if (hit_data) begin
            case (phase_q)
                PH_GRN: phase_q <= PH_BLU;
                PH_BLU: begin
                    phase_q <= PH_RED;
                    ptr_q   <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
                end
                default: phase_q <= PH_GRN;
            endcase
        end
    end

endmodule

// File: rtl/clut_store.sv
module clut_store
    import clut_pkg::*;
#(
    parameter int unsigned ENTRIES = 256,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_COMP-1:0] comp_we,
    input  logic [IDX_W-1:0]  wr_entry,
    input  logic [COMP_W-1:0] wr_byte,
    input  logic [IDX_W-1:0]  rd_entry,
    output rgb_t              rd_colour
);
    logic [N_COMP-1:0][COMP_W-1:0] rd_byte;

    // one independent byte plane per component
    for (genvar c = 0; c < N_COMP; c++) begin : g_plane
        logic [COMP_W-1:0] plane [ENTRIES];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < ENTRIES; i++)
                    plane[i] <= init_byte(i, ENTRIES);
            end else if (comp_we[c]) begin
                plane[wr_entry] <= wr_byte;
            end
        end

        assign rd_byte[c] = plane[rd_entry];
    end

    assign rd_colour.r = rd_byte[0];
    assign rd_colour.g = rd_byte[1];
    assign rd_colour.b = rd_byte[2];

endmodule

// File: rtl/clut_lookup.sv
module clut_lookup
    import clut_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rgb_t colour_in,
    output rgb_t colour_q
);
    always_ff @(posedge clk) begin
        if (rst) colour_q <= '0;
        else     colour_q <= colour_in;
    end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned ADDR_W  = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned PIX_W  = N_COMP * COMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]  pix_idx,
    output logic [PIX_W-1:0]  pix_color
);
    logic [N_COMP-1:0] comp_we;
    logic [IDX_W-1:0]  cur_idx;
    logic [COMP_W-1:0] wr_byte;
    logic [1:0]        cur_phase;
    rgb_t              rd_colour;
    rgb_t              out_colour;

    clut_regif #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_regif (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .comp_we (comp_we),
        .entry   (cur_idx),
        .wbyte   (wr_byte),
        .phase_o (cur_phase)
    );

    clut_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .comp_we   (comp_we),
        .wr_entry  (cur_idx),
        .wr_byte   (wr_byte),
        .rd_entry  (pix_idx),
        .rd_colour (rd_colour)
    );

    clut_lookup u_lookup (
        .clk       (clk),
        .rst       (rst),
        .colour_in (rd_colour),
        .colour_q  (out_colour)
    );

    assign pix_color = out_colour;
    assign bus_rdata = '0;

endmodule

// File: rtl/clut_checker.sv
module clut_checker #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned ADDR_W  = 4,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [IDX_W-1:0]  pix_idx,
    input logic [23:0]       pix_color,
    input logic [IDX_W-1:0]  wr_index,
    input logic [1:0]        wr_phase
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic data_wr;
    logic ptr_wr;
    logic other_wr;
    assign data_wr  = bus_wr && (bus_addr == ADDR_W'(4));
    assign ptr_wr   = bus_wr && (bus_addr == ADDR_W'(0));
    assign other_wr = bus_wr && !data_wr && !ptr_wr;

    p_reset_state_r4: assert property (@(posedge clk)
        rst |=> (wr_index == '0 && wr_phase == 2'd0));

    p_ptr_load_r1: assert property (@(posedge clk) disable iff (rst)
        ptr_wr |=> (wr_phase == 2'd0 &&
                    wr_index == $past(bus_wdata[31 -: IDX_W])));

    p_red_to_green_r2: assert property (@(posedge clk) disable iff (rst)
        (data_wr && wr_phase == 2'd0) |=> (wr_phase == 2'd1 && $stable(wr_index)));

    p_green_to_blue_r2: assert property (@(posedge clk) disable iff (rst)
        (data_wr && wr_phase == 2'd1) |=> (wr_phase == 2'd2 && $stable(wr_index)));

    p_blue_advance_r3: assert property (@(posedge clk) disable iff (rst)
        (data_wr && wr_phase == 2'd2) |=>
            (wr_phase == 2'd0 &&
             wr_index == (($past(wr_index) == LAST) ? '0 : $past(wr_index) + 1'b1)));

    p_stray_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        other_wr |=> ($stable(wr_index) && $stable(wr_phase)));

    p_lookup_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!bus_wr) && $stable(pix_idx)) |=> $stable(pix_color));

endmodule

bind clut_loader clut_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pix_idx   (pix_idx),
    .pix_color (pix_color),
    .wr_index  (cur_idx),
    .wr_phase  (cur_phase)
);

// File: tb/sim_clut_loader.sv
`timescale 1ns/1ps
module sim_clut_loader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_color;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model of the table and load state
    logic [7:0] m_r [256];
    logic [7:0] m_g [256];
    logic [7:0] m_b [256];
    logic [7:0] m_ptr;
    int         m_ph;

    always #2.5 clk = ~clk;

    clut_loader u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_color(pix_color)
    );

    function automatic logic [23:0] exp_col(input logic [7:0] i);
        return {m_r[i], m_g[i], m_b[i]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 256; i++) begin
            m_r[i] = (i == 255) ? 8'hFF : 8'h00;
            m_g[i] = m_r[i];
            m_b[i] = m_r[i];
        end
        m_ptr = 8'd0;
        m_ph  = 0;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] d);
        if (a == 4'h0) begin
            m_ptr = d[31:24];
            m_ph  = 0;
        end else if (a == 4'h4) begin
            case (m_ph)
                1: begin m_g[m_ptr] = d[31:24]; m_ph = 2; end
                2: begin m_b[m_ptr] = d[31:24]; m_ph = 0; m_ptr = m_ptr + 8'd1; end
                default: begin m_r[m_ptr] = d[31:24]; m_ph = 1; end
            endcase
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        check("R5", bus_rdata, 32'h0);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic look(input string req, input logic [7:0] i);
        @(negedge clk);
        pix_idx = i;
        @(negedge clk);
        check(req, {8'h0, pix_color}, {8'h0, exp_col(i)});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: power-up table contents, full sweep
        for (int i = 0; i < 256; i++) look("R4", 8'(i));
        check("R5", bus_rdata, 32'h0);

        // R8: one-cycle latency, old colour held until the next edge
        look("R8", 8'd255);
        @(negedge clk);
        pix_idx = 8'd254;
        #1 check("R8", {8'h0, pix_color}, 32'h00FFFFFF);
        @(negedge clk);
        check("R8", {8'h0, pix_color}, 32'h0);

        // R4: pointer/phase start at entry 0, red
        wr(4'h4, 32'h11AABBCC);
        wr(4'h4, 32'h22000000);
        wr(4'h4, 32'h33000000);
        look("R4", 8'd0);
        check("R4", {8'h0, pix_color}, 32'h00112233);
        wr(4'h4, 32'h44000000);
        look("R3", 8'd1);

        // R7: component-by-component visibility on entry 5
        wr(4'h0, 32'h05000000);
        wr(4'h4, 32'hA0000000);
        look("R7", 8'd5);
        check("R7", {8'h0, pix_color}, 32'h00A00000);
        wr(4'h4, 32'hB0000000);
        look("R7", 8'd5);
        check("R7", {8'h0, pix_color}, 32'h00A0B000);
        wr(4'h4, 32'hC0000000);
        look("R2", 8'd5);
        check("R2", {8'h0, pix_color}, 32'h00A0B0C0);

        // R8: lookup independent of pointer
        look("R8", 8'd0);

        // R1: rewriting the pointer mid-entry restarts at red
        wr(4'h0, 32'h07000000);
        wr(4'h4, 32'h70000000);
        wr(4'h0, 32'h09FFFFFF);
        wr(4'h4, 32'h91000000);
        wr(4'h4, 32'h92000000);
        wr(4'h4, 32'h93000000);
        look("R1", 8'd7);
        check("R1", {8'h0, pix_color}, 32'h00700000);
        look("R1", 8'd9);
        check("R1", {8'h0, pix_color}, 32'h00919293);
        look("R3", 8'd10);

        // R3: wrap from 255 to 0
        wr(4'h0, 32'hFF000000);
        wr(4'h4, 32'h01000000);
        wr(4'h4, 32'h02000000);
        wr(4'h4, 32'h03000000);
        wr(4'h4, 32'h04000000);
        wr(4'h4, 32'h05000000);
        wr(4'h4, 32'h06000000);
        look("R3", 8'd255);
        check("R3", {8'h0, pix_color}, 32'h00010203);
        look("R3", 8'd0);
        check("R3", {8'h0, pix_color}, 32'h00040506);

        // R6: stray offsets mid-entry leave pointer and phase alone
        wr(4'h0, 32'h20000000);
        wr(4'h4, 32'h21000000);
        wr(4'h8, 32'h99000000);
        wr(4'hC, 32'h98000000);
        wr(4'h1, 32'h97000000);
        wr(4'h5, 32'h96000000);
        wr(4'h4, 32'h22000000);
        wr(4'h4, 32'h23000000);
        look("R6", 8'd32);
        check("R6", {8'h0, pix_color}, 32'h00212223);
        look("R6", 8'd33);

        // seeded random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned sel;
            logic [3:0] a;
            sel = $urandom % 8;
            case (sel)
                0:       a = 4'h0;
                5:       a = 4'h8;
                6:       a = 4'hC;
                7:       a = 4'($urandom % 16);
                default: a = 4'h4;
            endcase
            wr(a, $urandom);
            if (($urandom % 2) == 0) look("R2", m_ptr - 8'd1);
            else                     look("R6", 8'($urandom % 256));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule